// File: doc/BRIEF.md
# Dual-Mode ADC Serial Output Interface

This block is the digital serial port of a 16-bit sampling converter. A rising edge on the convert strobe starts a conversion, and the level of the serial data input at that edge picks one of two interface modes for the whole conversion and the readout that follows. When an external conversion-done pulse arrives, the block captures the 16-bit result and shifts it out most significant bit first. Each falling edge of the serial clock advances the output by one bit. All pins are sampled in the system clock domain, and the serial clock is treated as a slow oversampled signal.

In select mode the output pin is driven only while the convert strobe or the data input is low. If either of them is low at the moment the conversion finishes, the output first presents a high level as a completion flag, and the data bits follow on later serial clock edges. In chain mode the output is always driven. The local word is shifted out first, and the data input is shifted in behind it, so the words of upstream converters follow on the same line with no gap. A new convert edge during a readout aborts that readout and selects the mode again.

Top module: `adc_sport`

## Requirements
- R1: While reset is asserted, and until the first convert edge after it, `sdo_oe` is 0 and `sdo` is 0.
- R2: At each rising edge of `cnv`, the level of `sdi` selects the mode for that conversion: 0 selects chain mode and 1 selects select mode.
- R3: In select mode, from the convert edge onward, `sdo_oe` is 1 exactly when `cnv` is 0 or `sdi` is 0, and 0 otherwise.
- R4: While a conversion is in progress, `sdo` is 0 and falling edges of `sck` do not change the result that is later shifted out.
- R5: When `conv_done` ends a conversion without a completion flag, `sdo` presents result bit 15 on the next clock. Each later `sck` falling edge moves on to the next lower bit, and zeros follow bit 0 in select mode.
- R6: In select mode, if `cnv` or `sdi` is 0 in the cycle where `conv_done` ends the conversion, `sdo` goes to 1. Result bit 15 then appears after the first `sck` falling edge, and the lower bits follow one per edge.
- R7: In chain mode, the local result goes out first, bit 15 first. The `sdi` level sampled at the k-th `sck` falling edge after completion appears on `sdo` after falling edge k+15, so the upstream word's bit 15 directly follows the local bit 0.
- R8: In chain mode, `sdo_oe` stays 1 from the convert edge onward, whatever the levels of `cnv` and `sdi`.
- R9: A rising edge of `cnv` during a readout aborts it: the next clock shows a conversion in progress (`sdo` = 0), with the mode chosen again from `sdi`.
- R10: A `conv_done` pulse that arrives outside a conversion has no effect on the bits that are shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv | input | 1 | Convert strobe; its rising edge starts a conversion; also an output enable in select mode |
| sck | input | 1 | Serial clock from the host; the output advances on its falling edge |
| sdi | input | 1 | Mode select at the convert edge; an enable in select mode; upstream data in chain mode |
| conv_done | input | 1 | One-cycle pulse marking the end of the analog conversion |
| result | input | 16 | Conversion result, valid while `conv_done` is high |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Output enable for `sdo` (0 means high-impedance) |

## Verification
The output enable is combinational from `cnv`, `sdi` and the registered mode, so it is due in the same cycle that those pins change. `sdo` comes from a register, so it is due one clock after the rising edge that registers a convert edge, a `conv_done` pulse or a serial clock fall. A serial clock fall is seen at the first rising clock edge after `sck` goes low. The bench drives every pin just after a falling clock edge and samples at the next falling edge, so exactly one register stage lies between stimulus and check. Random trials in both modes, and directed cases for the flag, the abort, late done pulses and ignored serial clocks, are compared against a bench model of the 17-bit output frame.

// File: rtl/adc_sport_pkg.sv
package adc_sport_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CONV = 2'd1,
    PH_READ = 2'd2
  } phase_t;

  typedef enum logic {
    IF_SEL   = 1'b0,
    IF_CHAIN = 1'b1
  } ifmode_t;

  // mode chosen from the data-input level at the convert edge
  function automatic ifmode_t pick_mode(input logic sdi_lvl);
    return sdi_lvl ? IF_SEL : IF_CHAIN;
  endfunction

  // completion flag requested when either enable is low at conversion end
  function automatic logic flag_request(input ifmode_t m, input logic cnv_lvl,
                                        input logic sdi_lvl);
    return (m == IF_SEL) && (!cnv_lvl || !sdi_lvl);
  endfunction

  // output is driven in chain mode always, in select mode when an enable is low
  function automatic logic drive_enable(input phase_t ph, input ifmode_t m,
                                        input logic cnv_lvl, input logic sdi_lvl);
    return (ph != PH_IDLE) && ((m == IF_CHAIN) || !cnv_lvl || !sdi_lvl);
  endfunction

endpackage

// File: rtl/adc_sport_edge.sv
module adc_sport_edge #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lvl,
  output logic [LANES-1:0] rise,
  output logic [LANES-1:0] fall
);
  logic [LANES-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rise[g] = lvl[g] & ~lvl_q[g];
    assign fall[g] = ~lvl[g] & lvl_q[g];
  end
endmodule

// File: rtl/adc_sport_ctrl.sv
module adc_sport_ctrl
  import adc_sport_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cnv,
  input  logic    sdi,
  input  logic    cnv_rise,
  input  logic    conv_done,
  output phase_t  phase,
  output ifmode_t mode,
  output logic    done_evt,
  output logic    flag_take
);
  // a convert edge always wins over a coincident done pulse
  assign done_evt  = conv_done && (phase == PH_CONV) && !cnv_rise;
  assign flag_take = done_evt && flag_request(mode, cnv, sdi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      mode  <= IF_SEL;
    end else if (cnv_rise) begin
      phase <= PH_CONV;
      mode  <= pick_mode(sdi);
    end else if (done_evt) begin
      phase <= PH_READ;
    end
  end
endmodule

// File: rtl/adc_sport_shift.sv
module adc_sport_shift #(
  parameter int W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       load_flag,
  input  logic       chain_sel,
  input  logic [W-1:0] word,
  input  logic       step,
  input  logic       fill,
  output logic [W:0] frame,
  output logic       tap_bit
);
  localparam int FW = W + 1;

  // chain: word in low bits, tapped one below the top, no gap to upstream data
  // flagged: a leading one ahead of the word; plain select: word in the top bits
  function automatic logic [FW-1:0] frame_load(input logic [W-1:0] w,
                                               input logic flg, input logic chn);
    if (chn)      return {1'b0, w};
    else if (flg) return {1'b1, w};
    else          return {w, 1'b0};
  endfunction

  function automatic logic [FW-1:0] frame_step(input logic [FW-1:0] f,
                                               input logic in_bit);
    return {f[FW-2:0], in_bit};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    frame <= '0;
    else if (load) frame <= frame_load(word, load_flag, chain_sel);
    else if (step) frame <= frame_step(frame, fill);
  end

  assign tap_bit = chain_sel ? frame[W-1] : frame[W];
endmodule

// File: rtl/adc_sport_drive.sv
module adc_sport_drive
  import adc_sport_pkg::*;
(
  input  phase_t  phase,
  input  ifmode_t mode,
  input  logic    cnv,
  input  logic    sdi,
  input  logic    tap_bit,
  output logic    sdo,
  output logic    sdo_oe
);
  assign sdo_oe = drive_enable(phase, mode, cnv, sdi);
  assign sdo    = (phase == PH_READ) ? tap_bit : 1'b0;
endmodule

// File: rtl/adc_sport.sv
module adc_sport #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv,
  input  logic              sck,
  input  logic              sdi,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] result,
  output logic              sdo,
  output logic              sdo_oe
);
  import adc_sport_pkg::*;

  localparam int FRAME_W = DATA_W + 1;

  logic [1:0]         rise_v;
  logic [1:0]         fall_v;
  logic               cnv_rise;
  logic               sck_fall;
  phase_t             phase;
  ifmode_t            mode;
  logic               done_evt;
  logic               flag_take;
  logic               chain_sel;
  logic               shift_step;
  logic               shift_fill;
  logic [FRAME_W-1:0] frame;
  logic               tap_bit;

  adc_sport_edge #(.LANES(2)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  ({sck, cnv}),
    .rise (rise_v),
    .fall (fall_v)
  );

  assign cnv_rise = rise_v[0];
  assign sck_fall = fall_v[1];

  adc_sport_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnv      (cnv),
    .sdi      (sdi),
    .cnv_rise (cnv_rise),
    .conv_done(conv_done),
    .phase    (phase),
    .mode     (mode),
    .done_evt (done_evt),
    .flag_take(flag_take)
  );

  assign chain_sel  = (mode == IF_CHAIN);
  assign shift_step = sck_fall && (phase == PH_READ) && !cnv_rise;
  assign shift_fill = chain_sel ? sdi : 1'b0;

  adc_sport_shift #(.W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (done_evt),
    .load_flag(flag_take),
    .chain_sel(chain_sel),
    .word     (result),
    .step     (shift_step),
    .fill     (shift_fill),
    .frame    (frame),
    .tap_bit  (tap_bit)
  );

  adc_sport_drive u_drive (
    .phase  (phase),
    .mode   (mode),
    .cnv    (cnv),
    .sdi    (sdi),
    .tap_bit(tap_bit),
    .sdo    (sdo),
    .sdo_oe (sdo_oe)
  );
endmodule

// File: rtl/adc_sport_chk.sv
module adc_sport_chk
  import adc_sport_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnv,
  input logic         sdi,
  input logic         conv_done,
  input logic [W-1:0] result,
  input logic         cnv_rise,
  input logic         sck_fall,
  input logic         done_evt,
  input logic         flag_take,
  input phase_t       phase,
  input ifmode_t      mode,
  input logic [W:0]   frame,
  input logic         sdo,
  input logic         sdo_oe
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!sdo_oe && !sdo));

  p_mode_pick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_rise |=> (mode == ($past(sdi) ? IF_SEL : IF_CHAIN)));

  p_sel_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == IF_SEL && cnv && sdi) |-> !sdo_oe);

  p_conv_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CONV) |-> !sdo);

  p_sck_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CONV && !done_evt) |=> $stable(frame));

  p_load_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !flag_take) |=> (sdo == $past(result[W-1])));

  p_flag_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_take |=> sdo);

  p_chain_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_READ && mode == IF_CHAIN && sck_fall && !cnv_rise)
    |=> (frame[0] == $past(sdi)));

  p_chain_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && mode == IF_CHAIN) |-> sdo_oe);

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_rise |=> (phase == PH_CONV && !sdo));

  p_late_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && phase == PH_READ && !cnv_rise && !sck_fall) |=> $stable(frame));
endmodule

bind adc_sport adc_sport_chk #(.W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnv      (cnv),
  .sdi      (sdi),
  .conv_done(conv_done),
  .result   (result),
  .cnv_rise (cnv_rise),
  .sck_fall (sck_fall),
  .done_evt (done_evt),
  .flag_take(flag_take),
  .phase    (phase),
  .mode     (mode),
  .frame    (frame),
  .sdo      (sdo),
  .sdo_oe   (sdo_oe)
);

// File: tb/adc_sport_bench.sv
module adc_sport_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int SEED       = 1234;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnv = 1'b0;
  logic        sck = 1'b0;
  logic        sdi = 1'b1;
  logic        conv_done = 1'b0;
  logic [15:0] result = '0;
  logic        sdo;
  logic        sdo_oe;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench model: 0 idle, 1 converting, 2 reading
  int          m_phase = 0;
  bit          m_chain = 0;
  logic [16:0] m_frame = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_sport u_adc_sport (
    .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .sdi(sdi),
    .conv_done(conv_done), .result(result), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  function automatic logic [16:0] f_load(input logic [15:0] w, input bit flg,
                                         input bit chn);
    logic [16:0] f;
    if (chn)      f = {1'b0, w};
    else if (flg) f = {1'b1, w};
    else          f = {w, 1'b0};
    return f;
  endfunction

  function automatic logic exp_sdo();
    if (m_phase != 2) return 1'b0;
    return m_chain ? m_frame[15] : m_frame[16];
  endfunction

  function automatic logic exp_oe();
    if (m_phase == 0) return 1'b0;
    return m_chain || !cnv || !sdi;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic chk_pins(input string tag);
    chk({tag, " sdo"}, sdo, exp_sdo());
    chk({tag, " sdo_oe"}, sdo_oe, exp_oe());
  endtask

  // drop cnv for one cycle, then raise it with the chosen sdi level
  task automatic start_conv(input logic sdi_lvl);
    cnv = 1'b0;
    @(negedge clk);
    sdi = sdi_lvl;
    cnv = 1'b1;
    @(negedge clk);
    m_phase = 1;
    m_chain = !sdi_lvl;
  endtask

  task automatic finish_conv(input logic [15:0] w, input logic cnv_lvl,
                             input logic sdi_lvl);
    bit flg;
    cnv = cnv_lvl;
    sdi = sdi_lvl;
    result = w;
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    result = $urandom;
    flg = !m_chain && (!cnv_lvl || !sdi_lvl);
    m_frame = f_load(w, flg, m_chain);
    m_phase = 2;
  endtask

  task automatic sck_pulse(input logic sdi_lvl);
    sdi = sdi_lvl;
    sck = 1'b1;
    @(negedge clk);
    sck = 1'b0;
    @(negedge clk);
    if (m_phase == 2) m_frame = {m_frame[15:0], m_chain ? sdi_lvl : 1'b0};
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog all-R actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    logic        rec [1:32];
    void'($urandom(SEED));

    // R1: reset and idle after reset
    repeat (3) @(negedge clk);
    chk_pins("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_pins("R1 after reset");
    cnv = 1'b0; sdi = 1'b0;
    @(negedge clk);
    chk("R1 idle ignores enables sdo_oe", sdo_oe, 1'b0);

    // R2/R3/R5: select mode, no flag
    start_conv(1'b1);
    chk_pins("R2 select picked, R3 float");
    chk("R3 floats with cnv and sdi high", sdo_oe, 1'b0);
    sdi = 1'b0;
    #1 chk("R3 sdi low enables", sdo_oe, 1'b1);
    chk("R4 low while converting", sdo, 1'b0);
    sdi = 1'b1;
    // R4: sck edges during conversion ignored
    sck_pulse(1'b1);
    sck_pulse(1'b1);
    chk_pins("R4 sck in conversion");
    finish_conv(16'hA5C3, 1'b1, 1'b1);
    chk_pins("R5 floating after done");
    cnv = 1'b0;
    @(negedge clk);
    chk("R5 msb first", sdo, 1'b1);
    chk_pins("R5 first bit");
    for (int i = 0; i < 18; i++) begin
      sck_pulse(1'b1);
      chk_pins("R5 shift");
    end

    // R6: completion flag with cnv low at done
    start_conv(1'b1);
    cnv = 1'b0;
    @(negedge clk);
    chk_pins("R4 busy low");
    chk("R4 driven low during conversion", sdo, 1'b0);
    finish_conv(16'h3C96, 1'b0, 1'b1);
    chk("R6 flag high", sdo, 1'b1);
    sck_pulse(1'b1);
    chk("R6 msb after first edge", sdo, 1'b0);
    for (int i = 0; i < 16; i++) begin
      sck_pulse(1'b1);
      chk_pins("R6 shift");
    end

    // R7/R8: chain mode with upstream data
    start_conv(1'b0);
    sdi = 1'b1;
    #1 chk("R8 chain drives with sdi high", sdo_oe, 1'b1);
    w = 16'h8E71;
    finish_conv(w, 1'b1, 1'b0);
    chk("R7 local msb", sdo, w[15]);
    for (int k = 1; k <= 32; k++) begin
      rec[k] = 1'($urandom);
      sck_pulse(rec[k]);
      chk_pins("R7 chain shift");
      if (k <= 15) chk("R7 local bits", sdo, w[15-k]);
      else         chk("R7 upstream delay", sdo, rec[k-15]);
    end
    cnv = 1'b0;
    #1 chk("R8 chain drives with cnv low", sdo_oe, 1'b1);

    // R10: done pulse during readout ignored
    start_conv(1'b0);
    finish_conv(16'hF00F, 1'b1, 1'b0);
    sck_pulse(1'b0);
    conv_done = 1'b1; result = 16'h0FF0;
    @(negedge clk);
    conv_done = 1'b0;
    chk_pins("R10 late done");
    for (int i = 0; i < 6; i++) begin
      sck_pulse(1'b0);
      chk_pins("R10 bits after late done");
    end

    // R9: abort chain readout, restart in select mode
    start_conv(1'b1);
    chk("R9 abort shows conversion", sdo, 1'b0);
    chk_pins("R9 mode relatched to select");
    finish_conv(16'h1234, 1'b1, 1'b1);
    cnv = 1'b0;
    @(negedge clk);
    chk_pins("R9 new word msb");
    sck_pulse(1'b1);
    chk_pins("R9 new word bit");

    // random trials in both modes
    for (int t = 0; t < 24; t++) begin
      bit chn;
      bit flg;
      int nf;
      chn = 1'($urandom);
      flg = 1'($urandom);
      w   = 16'($urandom);
      nf  = 4 + int'($urandom % 18);
      start_conv(chn ? 1'b0 : 1'b1);
      chk_pins(chn ? "R2 random chain" : "R2 random select");
      if (chn) begin
        finish_conv(w, 1'b1, 1'b0);
      end else if (flg) begin
        cnv = 1'b0;
        @(negedge clk);
        finish_conv(w, 1'b0, 1'b1);
        chk("R6 random flag", sdo, 1'b1);
      end else begin
        finish_conv(w, 1'b1, 1'b1);
        cnv = 1'b0;
        @(negedge clk);
        chk("R5 random msb", sdo, w[15]);
      end
      for (int i = 0; i < nf; i++) begin
        sck_pulse(chn ? 1'($urandom) : 1'b1);
        chk_pins(chn ? "R7 random chain" : "R5 random select");
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule